// File: doc/BRIEF.md
# Chainable Serial Code Loader for a 16-bit Converter

This block is the digital front end of a serial-input voltage-output converter. Three serial wires are sampled in a faster system clock: a bit clock, a data bit and an active-low select strobe whose rising edge commits the word. Bits are shifted into a 16-bit register on each qualified bit-clock rising edge while the select is low. When the select returns high, the register is copied into the holding register that feeds the converter code. The last shift stage is driven out so that several devices can share the bit clock and select, with each device's serial output feeding the next device's data input.

An active-low clear input and an undervoltage indication both set a sticky override flag. While the flag is set, the analog side drives the external reset level instead of the code. The flag is released only by the next commit edge. An active-low status output follows the undervoltage indication.

Top module: `sdac_front`

## Requirements
- R1: While `csLoadIn` is low, each rising edge of the internal bit clock (`sclkIn` AND NOT `csLoadIn`, as seen after synchronization) shifts `sdin` into bit 0 of the shift register and moves the other bits up by one. A 16-bit word therefore arrives most significant bit first.
- R2: While `csLoadIn` is high, `sclkIn` edges do not change the shift register. This is observable as a steady `sdout` and an unchanged code at the next commit.
- R3: A rising edge of `csLoadIn` copies the shift register into `dacCode`. `dacCode` changes at no other time.
- R4: `sdout` is bit 15 of the shift register and changes only on a shift. After 16 shifts it has presented the previous word, so two chained devices hold the second and first of 32 bits after one shared commit.
- R5: If `csLoadIn` falls while `sclkIn` is high, the internal clock rises and one extra bit (the current `sdin`) is shifted in.
- R6: `clrN` low or `uvIn` high sets `useResetLevel`. The flag stays at 1 after the cause is removed and clears only on a commit edge.
- R7: If a commit edge and an active set cause fall in the same cycle, `useResetLevel` stays at 1 while `dacCode` still takes the new word.
- R8: `rstStatN` is the inverse of `uvIn`, delayed by exactly 3 system clocks (two synchronizer stages plus one register).
- R9: After `rstN` is released, `dacCode` is 0, `sdout` is 0, `useResetLevel` is 1 and `rstStatN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| sclkIn | input | 1 | Serial bit clock |
| sdin | input | 1 | Serial data in |
| csLoadIn | input | 1 | Select (low) and commit strobe (rising edge) |
| clrN | input | 1 | Clear to reset level, active low |
| uvIn | input | 1 | Undervoltage indication, active high |
| sdout | output | 1 | Last shift stage, used for chaining |
| dacCode | output | 16 | Converter code from the holding register |
| useResetLevel | output | 1 | Sticky override: select the external reset level |
| rstStatN | output | 1 | Undervoltage status, active low |

## Verification
A commit edge and a set cause of the override can land in the same system cycle. In that case the holding register must load while the flag stays set. The bench provokes this by raising the select and pulling clear low on the same clock edge. It then requires the new code together with a set flag, and later requires that a second commit, made with clear released, drops the flag. A dropping select while the bit clock is high is the second overlap: one edge acts as both the start of the word and a shift. The bench judges it by comparing the committed words of both chained devices against its own model.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef struct packed {
    logic shift;
    logic load;
  } sdacStrobe_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkS,
  input  logic        csS,
  input  logic        clrNS,
  input  logic        uvS,
  output sdacStrobe_t strobe,
  output logic        overrideFlag,
  output logic        rstStatN
);
  logic gatedClk;
  logic gatedPrev;
  logic csPrev;
  logic setCause;

  // internal bit clock: serial clock qualified by select low
  assign gatedClk = sclkS & ~csS;
  assign setCause = ~clrNS | uvS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gatedPrev <= 1'b0;
      csPrev    <= 1'b1;
      rstStatN  <= 1'b1;
    end else begin
      gatedPrev <= gatedClk;
      csPrev    <= csS;
      rstStatN  <= ~uvS;
    end
  end

  always_comb begin
    strobe.shift = gatedClk & ~gatedPrev;
    strobe.load  = csS & ~csPrev;
  end

  // set has priority over the release by a commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            overrideFlag <= 1'b1;
    else if (setCause)    overrideFlag <= 1'b1;
    else if (strobe.load) overrideFlag <= 1'b0;
  end
endmodule

// File: rtl/sdac_dpath.sv
module sdac_dpath
  import sdac_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  sdacStrobe_t      strobe,
  input  logic             dataS,
  output logic [WIDTH-1:0] shiftWord,
  output logic [WIDTH-1:0] holdWord,
  output logic             serialOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftWord <= '0;
    else if (strobe.shift) shiftWord <= {shiftWord[WIDTH-2:0], dataS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdWord <= '0;
    else if (strobe.load) holdWord <= shiftWord;
  end

  assign serialOut = shiftWord[WIDTH-1];
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkIn,
  input  logic             sdin,
  input  logic             csLoadIn,
  input  logic             clrN,
  input  logic             uvIn,
  output logic             sdout,
  output logic [WIDTH-1:0] dacCode,
  output logic             useResetLevel,
  output logic             rstStatN
);
  localparam int NUM_IN = 5;
  localparam logic [NUM_IN-1:0] IN_RST = 5'b01100;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  sdacStrobe_t       strobe;
  logic [WIDTH-1:0]  shiftWord;
  logic              loadStb;
  logic              shiftStb;

  assign rawIn = {uvIn, clrN, csLoadIn, sdin, sclkIn};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IN_RST[i])) u_sync (
      .clk(clk), .rstN(rstN), .asyncIn(rawIn[i]), .syncOut(syncIn[i])
    );
  end

  sdac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclkS(syncIn[0]), .csS(syncIn[2]), .clrNS(syncIn[3]), .uvS(syncIn[4]),
    .strobe(strobe), .overrideFlag(useResetLevel), .rstStatN(rstStatN)
  );

  sdac_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataS(syncIn[1]),
    .shiftWord(shiftWord), .holdWord(dacCode), .serialOut(sdout)
  );

  assign loadStb  = strobe.load;
  assign shiftStb = strobe.shift;
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadStb,
  input logic             shiftStb,
  input logic [WIDTH-1:0] shiftWord,
  input logic [WIDTH-1:0] dacCode,
  input logic             sdout,
  input logic             useResetLevel,
  input logic             rstStatN
);
  p_code_on_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> dacCode == $past(shiftWord));

  p_code_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCode) |-> $past(loadStb));

  p_sdout_on_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdout) |-> $past(shiftStb));

  p_release_on_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(useResetLevel) |-> $past(loadStb));

  p_uv_forces_override_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rstStatN |-> useResetLevel);
endmodule

bind sdac_front sdac_front_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .loadStb(loadStb), .shiftStb(shiftStb),
  .shiftWord(shiftWord), .dacCode(dacCode), .sdout(sdout),
  .useResetLevel(useResetLevel), .rstStatN(rstStatN)
);

// File: tb/sdac_front_bench.sv
module sdac_front_bench;
  localparam int PERIOD = 10;
  localparam int HOLD   = 4;
  localparam int W      = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, sdin = 1'b0, csLoadIn = 1'b1, clrN = 1'b1, uvIn = 1'b0;
  logic sdoutA, sdoutB, flagA, flagB, statA, statB;
  logic [W-1:0] codeA, codeB;
  logic [W-1:0] expShA = '0, expShB = '0, expHoldA = '0, expHoldB = '0;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sdac_front u_sdac_front (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdin(sdin), .csLoadIn(csLoadIn),
    .clrN(clrN), .uvIn(uvIn), .sdout(sdoutA), .dacCode(codeA),
    .useResetLevel(flagA), .rstStatN(statA)
  );

  sdac_front u_sdac_front_b (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdin(sdoutA), .csLoadIn(csLoadIn),
    .clrN(clrN), .uvIn(uvIn), .sdout(sdoutB), .dacCode(codeB),
    .useResetLevel(flagB), .rstStatN(statB)
  );

  function automatic logic [W-1:0] shiftIn(logic [W-1:0] word, logic b);
    return {word[W-2:0], b};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitHold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic modelShift(logic b);
    expShB = shiftIn(expShB, expShA[W-1]);
    expShA = shiftIn(expShA, b);
  endtask

  task automatic sendBit(logic b);
    sclkIn = 1'b0; sdin = b; waitHold();
    sclkIn = 1'b1; modelShift(b); waitHold();
  endtask

  task automatic selectLow();
    sclkIn = 1'b0; waitHold();
    csLoadIn = 1'b0; waitHold();
  endtask

  task automatic commit();
    sclkIn = 1'b0; waitHold();
    csLoadIn = 1'b1; expHoldA = expShA; expHoldB = expShB; waitHold();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 codeA", codeA, 0);
    check("R9 sdout", sdoutA, 0);
    check("R9 flag", flagA, 1);
    check("R9 stat", statA, 1);

    // R1 R3 R4: chained words, random and directed
    for (int n = 0; n < 12; n++) begin
      logic [W-1:0] wA, wB;
      wB = (n == 0) ? 16'hFFFF : W'($urandom);
      wA = (n == 0) ? 16'h0000 : (n == 1) ? 16'h8001 : W'($urandom);
      selectLow();
      for (int i = W-1; i >= 0; i--) sendBit(wB[i]);
      check("R4 sdout mid-chain", sdoutA, expShA[W-1]);
      for (int i = W-1; i >= 0; i--) sendBit(wA[i]);
      commit();
      check("R1 R3 codeA", codeA, wA);
      check("R4 codeB chained", codeB, wB);
      check("R3 model A", codeA, expHoldA);
    end
    check("R6 flag released by load", flagA, 0);

    // R2: clock activity while select high is ignored
    begin
      logic sd0;
      sd0 = sdoutA;
      for (int i = 0; i < 6; i++) begin
        sdin = 1'($urandom); sclkIn = ~sclkIn; waitHold();
        check("R2 sdout steady", sdoutA, sd0);
      end
      sclkIn = 1'b0; waitHold();
      selectLow();
      commit();
      check("R2 code unchanged", codeA, expHoldA);
    end

    // R5: select falls while clock high -> extra shift
    sclkIn = 1'b1; sdin = 1'b1; waitHold();
    csLoadIn = 1'b0; modelShift(1'b1); waitHold();
    for (int i = 0; i < W-1; i++) sendBit(1'b0);
    commit();
    check("R5 extra bit codeA", codeA, 16'h8000);
    check("R5 extra bit codeB", codeB, expHoldB);

    // R6: clear sets a sticky flag
    clrN = 1'b0; waitHold();
    check("R6 flag set by clear", flagA, 1);
    clrN = 1'b1; repeat (3) waitHold();
    check("R6 flag sticky", flagA, 1);
    selectLow();
    sendBit(1'b1);
    commit();
    check("R6 flag cleared by load", flagA, 0);

    // R7: commit edge and clear in the same cycle
    selectLow();
    for (int i = 0; i < W; i++) sendBit(1'($urandom));
    sclkIn = 1'b0; waitHold();
    csLoadIn = 1'b1; clrN = 1'b0; expHoldA = expShA; waitHold();
    check("R7 code loaded", codeA, expHoldA);
    check("R7 flag kept", flagA, 1);
    clrN = 1'b1; waitHold();
    selectLow();
    commit();
    check("R7 flag cleared later", flagA, 0);

    // R8: status latency of exactly 3 clocks
    uvIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 stat before latency", statA, 1);
    @(negedge clk);
    check("R8 stat low", statA, 0);
    check("R6 flag set by uv", flagA, 1);
    uvIn = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 stat still low", statA, 0);
    @(negedge clk);
    check("R8 stat high", statA, 1);
    check("R6 flag sticky after uv", flagA, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule